// File: doc/BRIEF.md
# Clock Mode Decoder with Test Dividers

This block turns a three-bit clock select (one speed bit and a two-bit function field) into per-group drive enables, per-group rate codes and, in test mode, real divided clocks for seven output groups. The groups are the CPU clock, the half-rate CPU clock, the 66 MHz clock, the PCI clock, the 48 MHz clock, the reference clock and the interrupt-controller clock. In the frequency modes the analog synthesizer rates are only reported as rate codes. In test mode the block derives every group clock from the single input clock with one free-running counter.

The select is registered on the input clock. After any change of the registered select, a lock-wait interval of `lock_len` cycles stands in for synthesizer settling. During that interval every group clock is held low while the drive enables already follow the new mode. Undefined select codes behave like the all-off code, so no output is driven in an undefined mode.

Group index g (bit g of `grp_oe` and `grp_clk`, field `grp_ratio[4g+3:4g]`): 0 CPU, 1 CPU/2, 2 66 MHz, 3 PCI, 4 48 MHz, 5 REF, 6 APIC.

Top module: `clkmode_decoder`

## Requirements
- R1: Select codes 000, 001 and 101 (written speed, f1, f0) give `grp_oe` = 0, every rate code 0 (off) and every `grp_clk` low.
- R2: Codes 010 and 110 enable groups 0-3, 5 and 6 and leave group 4 (48 MHz) disabled with rate code 0.
- R3: Codes 011 and 111 enable all seven groups, and group 4 reports rate code 6 (48 MHz).
- R4: In the frequency modes, speed bit 0 gives CPU code 1 (100 MHz) and CPU/2 code 3 (50 MHz). Speed bit 1 gives CPU code 2 (133 MHz) and CPU/2 code 4 (66 MHz).
- R5: In the frequency modes, the 66 MHz group reports code 4, PCI code 5 (33 MHz), REF code 7 (14.318 MHz) and APIC code 8 (16.67 MHz), whatever the speed bit.
- R6: Code 100 is test mode: all groups are enabled, and the rate codes give the division as 10 (/1), 11 (/2), 12 (/4), 13 (/8) or 14 (/16). The divisions are CPU /2, CPU/2 /4, 66 MHz /4, PCI /8, 48 MHz /2, REF /1, APIC /16.
- R7: In test mode, after lock-wait, each group clock shows 32 divided by its division rising edges in any 32 input-clock cycles.
- R8: The divider counter is zero whenever test mode is not running. The first cycle after the outputs start running has all group clocks low, and the next cycle has exactly groups 0 and 4 high.
- R9: A change of the select raises `lock_wait` for exactly `lock_len` cycles starting at the clock edge that registers the change. A `lock_len` of 0 gives no wait.
- R10: While `lock_wait` is high, every group clock is low.
- R11: Outside test mode every group clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test/reference clock; all registers and dividers run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_speed | input | 1 | Speed bit (0: 100 MHz CPU, 1: 133 MHz CPU) |
| sel_func | input | 2 | Function field {f1, f0} |
| lock_len | input | LOCK_W | Lock-wait length in cycles after a select change |
| lock_wait | output | 1 | High while the settling interval runs |
| grp_oe | output | 7 | Per-group drive enable |
| grp_clk | output | 7 | Per-group clock, active in test mode only |
| grp_ratio | output | 28 | Per-group 4-bit rate code |

## Verification
The assertions assume that the select and `lock_len` change only away from the rising clock edge and stay stable across it, and that `lock_len` is not changed during a wait it would alter. The bench drives every input on the falling edge and changes `lock_len` only while the block is idle. The assertions also assume that reset is held for at least one full clock. Period checks rely on the counter starting from zero, so the bench always enters test mode through a select change and counts edges only after `lock_wait` has dropped.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   localparam int NGRP    = 7;
   localparam int RATIO_W = 4;

   localparam int G_CPU  = 0;
   localparam int G_CPU2 = 1;
   localparam int G_M66  = 2;
   localparam int G_PCI  = 3;
   localparam int G_F48  = 4;
   localparam int G_REF  = 5;
   localparam int G_APIC = 6;

   typedef enum logic [1:0] {
      M_TRI  = 2'd0,
      M_NO48 = 2'd1,
      M_FULL = 2'd2,
      M_TEST = 2'd3
   } mode_e;

   typedef enum logic [RATIO_W-1:0] {
      RT_OFF   = 4'd0,
      RT_100   = 4'd1,
      RT_133   = 4'd2,
      RT_50    = 4'd3,
      RT_66    = 4'd4,
      RT_33    = 4'd5,
      RT_48    = 4'd6,
      RT_14    = 4'd7,
      RT_16    = 4'd8,
      RT_DIV1  = 4'd10,
      RT_DIV2  = 4'd11,
      RT_DIV4  = 4'd12,
      RT_DIV8  = 4'd13,
      RT_DIV16 = 4'd14
   } ratio_e;

   // log2 of the test-mode division for each group, indexed by group
   localparam int unsigned TEST_LOG2 [NGRP] = '{1, 2, 2, 3, 1, 0, 4};

   function automatic ratio_e div_code(int unsigned lg);
      case (lg)
         0:       return RT_DIV1;
         1:       return RT_DIV2;
         2:       return RT_DIV4;
         3:       return RT_DIV8;
         default: return RT_DIV16;
      endcase
   endfunction

   function automatic ratio_e norm_code(int g, logic fast);
      case (g)
         G_CPU:   return fast ? RT_133 : RT_100;
         G_CPU2:  return fast ? RT_66  : RT_50;
         G_M66:   return RT_66;
         G_PCI:   return RT_33;
         G_F48:   return RT_48;
         G_REF:   return RT_14;
         default: return RT_16;
      endcase
   endfunction

endpackage

// File: rtl/clkmode_sel_decode.sv
module clkmode_sel_decode
   import clkmode_pkg::*;
(
   input  logic [2:0] sel_code,
   output mode_e      mode
);

   always_comb begin
      case (sel_code)
         3'b100:         mode = M_TEST;
         3'b010, 3'b110: mode = M_NO48;
         3'b011, 3'b111: mode = M_FULL;
         default:        mode = M_TRI;   // off and reserved codes
      endcase
   end

endmodule

// File: rtl/clkmode_lock_timer.sv
module clkmode_lock_timer #(
   parameter int SEL_W  = 3,
   parameter int LOCK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_code,
   input  logic [LOCK_W-1:0] lock_len,
   output logic [SEL_W-1:0]  sel_q,
   output logic              lock_wait
);

   if (SEL_W != 3) begin : g_bad_sel
      $error("clkmode_lock_timer: SEL_W must be 3");
   end
   if (LOCK_W < 1) begin : g_bad_lock
      $error("clkmode_lock_timer: LOCK_W must be at least 1");
   end

   logic [LOCK_W-1:0] remain;
   logic              sel_chg;

   assign sel_chg   = (sel_code != sel_q);
   assign lock_wait = (remain != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         remain <= '0;
      end else begin
         sel_q <= sel_code;
         if (sel_chg)
            remain <= lock_len;
         else if (remain != '0)
            remain <= remain - 1'b1;
      end
   end

   // R9: a registered change with nonzero length starts the wait
   p_lock_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_chg && lock_len != '0) |=> lock_wait);

   // R9: with a stable select the wait never restarts by itself
   p_lock_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_chg && !lock_wait) |=> !lock_wait);

   // R9: a zero length gives no wait
   p_lock_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_chg && lock_len == '0) |=> !lock_wait);

endmodule

// File: rtl/clkmode_test_div.sv
module clkmode_test_div
   import clkmode_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   output logic [NGRP-1:0] div_clk
);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("clkmode_test_div: CNT_W must cover a divide by 16");
   end

   logic [CNT_W-1:0] cnt;
   logic             run_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // enable for the pass-through tap, changed only while clk is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         run_lo <= 1'b0;
      else
         run_lo <= run;
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_tap
      localparam int unsigned LG = TEST_LOG2[g];
      if (LG == 0) begin : g_pass
         assign div_clk[g] = clk & run_lo;
      end else begin : g_bit
         assign div_clk[g] = run & cnt[LG-1];
      end
   end

   // R8: the counter sits at zero after any cycle without run
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   // R7: while running the counter advances by one each cycle
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/clkmode_decoder.sv
module clkmode_decoder
   import clkmode_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int LOCK_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sel_speed,
   input  logic [1:0]                sel_func,
   input  logic [LOCK_W-1:0]         lock_len,
   output logic                      lock_wait,
   output logic [NGRP-1:0]           grp_oe,
   output logic [NGRP-1:0]           grp_clk,
   output logic [NGRP*RATIO_W-1:0]   grp_ratio
);

   localparam int SEL_W = 3;

   logic [SEL_W-1:0] sel_q;
   mode_e            mode;
   logic             run;
   logic [NGRP-1:0]  div_clk;

   clkmode_lock_timer #(.SEL_W(SEL_W), .LOCK_W(LOCK_W)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_code  ({sel_speed, sel_func}),
      .lock_len  (lock_len),
      .sel_q     (sel_q),
      .lock_wait (lock_wait)
   );

   clkmode_sel_decode u_dec (
      .sel_code (sel_q),
      .mode     (mode)
   );

   assign run = (mode == M_TEST) && !lock_wait;

   clkmode_test_div #(.CNT_W(CNT_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .div_clk (div_clk)
   );

   assign grp_clk = div_clk;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int GI = g;
      logic   oe_l;
      ratio_e rt_l;
      always_comb begin
         case (mode)
            M_NO48: begin
               oe_l = (GI != G_F48);
               rt_l = (GI == G_F48) ? RT_OFF : norm_code(GI, sel_q[2]);
            end
            M_FULL: begin
               oe_l = 1'b1;
               rt_l = norm_code(GI, sel_q[2]);
            end
            M_TEST: begin
               oe_l = 1'b1;
               rt_l = div_code(TEST_LOG2[GI]);
            end
            default: begin
               oe_l = 1'b0;
               rt_l = RT_OFF;
            end
         endcase
      end
      assign grp_oe[g] = oe_l;
      assign grp_ratio[g*RATIO_W +: RATIO_W] = rt_l;
   end

   // R1: the off and reserved codes drive nothing
   p_tri_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_TRI) |-> (grp_oe == '0 && grp_clk == '0));

   // R2: 48 MHz group stays undriven while its synthesizer is off
   p_no48_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_NO48) |-> (!grp_oe[G_F48] && grp_oe[G_CPU] && grp_oe[G_APIC]));

   // R3: full mode drives every group
   p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_FULL) |-> (grp_oe == '1));

   // R10: one cycle into a wait all divided clocks are low
   p_lock_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_wait |=> (grp_clk == '0));

   // R11: frequency modes never toggle the group clocks
   p_no_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != M_TEST && $past(mode) != M_TEST) |-> (grp_clk == '0));

endmodule

// File: tb/tb_clkmode_decoder.sv
module tb_clkmode_decoder;

   localparam int CLK_P  = 10;
   localparam int LOCK_W = 8;
   localparam int LEN    = 5;
   localparam int NG     = 7;
   localparam int NVEC   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sel_speed = 1'b0;
   logic [1:0]        sel_func = 2'b00;
   logic [LOCK_W-1:0] lock_len = LOCK_W'(LEN);
   logic              lock_wait;
   logic [NG-1:0]     grp_oe;
   logic [NG-1:0]     grp_clk;
   logic [NG*4-1:0]   grp_ratio;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   int edge_cnt [NG];

   always #(CLK_P/2) clk = ~clk;

   clkmode_decoder #(.CNT_W(4), .LOCK_W(LOCK_W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_speed (sel_speed),
      .sel_func  (sel_func),
      .lock_len  (lock_len),
      .lock_wait (lock_wait),
      .grp_oe    (grp_oe),
      .grp_clk   (grp_clk),
      .grp_ratio (grp_ratio)
   );

   initial for (int i = 0; i < NG; i++) edge_cnt[i] = 0;

   for (genvar g = 0; g < NG; g++) begin : g_edge
      always @(posedge grp_clk[g]) edge_cnt[g] = edge_cnt[g] + 1;
   end

   // vector: {select, expected enables, expected rate fields g6..g0}
   typedef struct packed {
      logic [2:0]  sel;
      logic [6:0]  oe;
      logic [27:0] rt;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{3'b010, 7'h6F, 28'h8705431},   // R2 R4 R5
      '{3'b011, 7'h7F, 28'h8765431},   // R3 R4 R5
      '{3'b110, 7'h6F, 28'h8705442},   // R2 R4 R5
      '{3'b111, 7'h7F, 28'h8765442},   // R3 R4 R5
      '{3'b001, 7'h00, 28'h0000000},   // R1 reserved
      '{3'b100, 7'h7F, 28'hEABDCCB},   // R6 test
      '{3'b101, 7'h00, 28'h0000000},   // R1 reserved
      '{3'b000, 7'h00, 28'h0000000}    // R1 off
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_sel(input logic [2:0] s);
      sel_speed = s[2];
      sel_func  = s[1:0];
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int snap [NG];
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(1);
      // reset state, select 000
      chk("R1", "reset oe", 32'(grp_oe), 32'h0);
      chk("R1", "reset ratio", 32'(grp_ratio), 32'h0);
      chk("R9", "reset lock_wait", 32'(lock_wait), 32'h0);
      chk("R11", "reset clocks", 32'(grp_clk), 32'h0);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         set_sel(VECS[v].sel);
         wait_neg(1);
         chk("R9", "lock_wait first cycle", 32'(lock_wait), 32'h1);
         wait_neg(LEN - 1);
         chk("R9", "lock_wait last cycle", 32'(lock_wait), 32'h1);
         chk("R10", "clocks during wait", 32'(grp_clk), 32'h0);
         wait_neg(1);
         chk("R9", "lock_wait after length", 32'(lock_wait), 32'h0);
         chk("R1 R2 R3 R6", "oe", 32'(grp_oe), 32'(VECS[v].oe));
         chk("R4 R5 R6", "ratio", 32'(grp_ratio), 32'(VECS[v].rt));
         chk("R8 R11", "clocks after wait", 32'(grp_clk), 32'h0);
      end

      // test mode phase and periods (currently in 000)
      set_sel(3'b100);
      wait_neg(LEN + 1);
      chk("R8", "first running cycle", 32'(grp_clk), 32'h0);
      wait_neg(1);
      chk("R8", "second running cycle", 32'(grp_clk), 32'h11);
      for (int g = 0; g < NG; g++) snap[g] = edge_cnt[g];
      wait_neg(32);
      begin
         int lg [NG] = '{1, 2, 2, 3, 1, 0, 4};
         for (int g = 0; g < NG; g++)
            chk("R7", $sformatf("edges group %0d", g),
                32'(edge_cnt[g] - snap[g]), 32'(32 >> lg[g]));
      end

      // zero lock length, then counter clear on re-entry
      lock_len = '0;
      set_sel(3'b011);
      wait_neg(1);
      chk("R9", "no wait with zero length", 32'(lock_wait), 32'h0);
      chk("R3", "oe with zero length", 32'(grp_oe), 32'h7F);
      chk("R11", "clocks in full mode", 32'(grp_clk), 32'h0);
      wait_neg(3);
      set_sel(3'b100);
      wait_neg(1);
      chk("R8", "re-entry first cycle", 32'(grp_clk), 32'h0);
      wait_neg(1);
      chk("R8", "re-entry second cycle", 32'(grp_clk), 32'h11);
      wait_neg(1);
      chk("R7", "re-entry third cycle", 32'(grp_clk), 32'h02 | 32'h04);

      // leaving test mode into reserved code drops everything
      lock_len = LOCK_W'(LEN);
      set_sel(3'b101);
      wait_neg(1);
      chk("R1", "reserved oe", 32'(grp_oe), 32'h0);
      chk("R10", "clocks at wait start", 32'(grp_clk), 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule